// File: doc/BRIEF.md
# Clock Stop Gate with Synchronized Request

This block takes one source clock and gives out a group of gated copies plus one free-running copy. An external active-low stop request arrives with no timing relation to the source clock. The block brings it into the source clock domain through a short flop chain. It then stops or restarts the gated copies only while the source clock is low. A stopped output therefore rests at logic low, and the first high phase after a restart is a full half period. Each output has its own enable bit, and an output whose bit is clear stays low.

The block is built once per clock group. A group that needs a stop latency below four cycles uses two synchronizer stages. A group that needs single-cycle latency uses one stage. A build option decides whether a mode qualifier gates the stop request. When the option is on and the qualifier is high, the request is ignored. A global tristate control drops the pad output enable for every output in the group.

Top module: `clk_stop_gate`

## Requirements
- R1: A stop request (stop_req_n low, held steady, and not masked by R6) is sampled on rising edges of clk_src. Each gated output then gives exactly SYNC_STAGES more rising edges and no more. The count starts at the first clk_src rising edge after the request. With the default of 2, that is fewer than 4 cycles.
- R2: While the stop is in effect, every gated output stays at logic low and never goes high.
- R3: After stop_req_n returns high, the first gated rising edge falls on the (SYNC_STAGES+1)th clk_src rising edge after the release. Every high phase on a gated output lasts a full half period of clk_src, even when out_en toggles at arbitrary times.
- R4: clk_free follows clk_src whatever the values of stop_req_n and mode_sel.
- R5: When out_en[i] is 0, clk_gated[i] stays low. When free_en is 0, clk_free stays low. When an enable is 1, the output toggles once per clk_src cycle. An enable change is taken on the next falling edge of clk_src.
- R6: With USE_MODE=1 (the default), mode_sel=1 masks the stop request and the gated outputs run. With mode_sel=0 the request acts.
- R7: pad_oe is 0 while tristate is 1, and 1 while tristate is 0.
- R8: While rst_n is low, clk_gated and clk_free are all held low and the synchronizer sits in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| mode_sel | input | 1 | Latched mode qualifier; 1 masks the stop when USE_MODE=1 |
| tristate | input | 1 | 1 turns off the pad drivers of the group |
| free_en | input | 1 | Enable for the free-running output |
| out_en | input | N_OUT | Enable per gated output |
| clk_gated | output | N_OUT | Gated clock outputs |
| clk_free | output | 1 | Free-running clock output |
| pad_oe | output | 1 | Pad output enable for the whole group |

## Verification
A stop or release applied between edges reaches the gated outputs through SYNC_STAGES rising-edge flops and then one falling-edge register. The bench therefore counts edges. For a stop it expects exactly SYNC_STAGES gated pulses after the request. For a release it expects the first pulse on edge SYNC_STAGES+1, and it samples two microseconds-free points: one edge before that pulse and the edge it appears on. For steady patterns the bench allows four settling cycles and then counts high phases over a fixed window of eight cycles, sampling one time unit after each rising edge. Pulse widths are timed on every gated edge so that any runt high phase is caught.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic {
        GATE_HALT = 1'b0,
        GATE_RUN  = 1'b1
    } gate_mode_e;

    // Stop demand before synchronization; the qualifier masks it when used.
    function automatic logic stop_demand(input logic req_n, input logic qual_mask);
        return (!req_n) && (!qual_mask);
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_st_t;

    sync_st_t state_d, state_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                state_d      = state_q;
                state_d.pipe = async_in;
            end
        end else begin : g_chain
            always_comb begin
                state_d      = state_q;
                state_d.pipe = {state_q.pipe[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sync_out = state_q.pipe[STAGES-1];

endmodule

// File: rtl/clkstop_cell.sv
module clkstop_cell
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_in,
    output logic clk_out
);

    typedef struct packed {
        gate_mode_e mode;
    } cell_st_t;

    cell_st_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.mode = en_in ? GATE_RUN : GATE_HALT;
    end

    // Enable is captured on the falling edge, so it only moves while clk is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{mode: GATE_HALT};
        end else begin
            state_q <= state_d;
        end
    end

    assign clk_out = clk & (state_q.mode == GATE_RUN);

    // R3: the gating term never changes during a high phase of the source
    always @(state_q) begin
        if (rst_n) begin
            p_enable_moves_low_r3: assert (!clk)
                else $error("gate enable changed while clock high");
        end
    end

endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
    import clkstop_pkg::*;
#(
    parameter int N_OUT       = 4,
    parameter int SYNC_STAGES = 2,
    parameter bit USE_MODE    = 1'b1
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             stop_req_n,
    input  logic             mode_sel,
    input  logic             tristate,
    input  logic             free_en,
    input  logic [N_OUT-1:0] out_en,
    output logic [N_OUT-1:0] clk_gated,
    output logic             clk_free,
    output logic             pad_oe
);

    localparam int LAG_W   = $clog2(SYNC_STAGES + 3);
    localparam int LAG_MAX = SYNC_STAGES + 1;

    logic qual_mask;
    logic stop_raw;
    logic stop_sync;

    generate
        if (USE_MODE) begin : g_mode_qual
            assign qual_mask = mode_sel;
        end else begin : g_no_qual
            assign qual_mask = 1'b0;
        end
    endgenerate

    assign stop_raw = stop_demand(stop_req_n, qual_mask);

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .async_in (stop_raw),
        .sync_out (stop_sync)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N_OUT; gi++) begin : g_cell
            clkstop_cell u_cell (
                .clk     (clk_src),
                .rst_n   (rst_n),
                .en_in   (out_en[gi] & ~stop_sync),
                .clk_out (clk_gated[gi])
            );
        end
    endgenerate

    clkstop_cell u_free (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .en_in   (free_en),
        .clk_out (clk_free)
    );

    assign pad_oe = ~tristate;

    // Group run state, falling-edge registered like the cells it mirrors
    typedef struct packed {
        gate_mode_e run;
    } grp_st_t;

    grp_st_t grp_d, grp_q;

    always_comb begin
        grp_d     = grp_q;
        grp_d.run = stop_sync ? GATE_HALT : GATE_RUN;
    end

    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= '{run: GATE_RUN};
        end else begin
            grp_q <= grp_d;
        end
    end

    // Lag tracker: cycles a steady demand has waited for the group state
    typedef struct packed {
        logic             raw_prev;
        logic [LAG_W-1:0] lag;
    } lag_st_t;

    lag_st_t lag_d, lag_q;
    logic    mismatch;

    assign mismatch = (stop_raw == (grp_q.run == GATE_RUN));

    always_comb begin
        lag_d          = lag_q;
        lag_d.raw_prev = stop_raw;
        if (!mismatch) begin
            lag_d.lag = '0;
        end else if (stop_raw != lag_q.raw_prev) begin
            lag_d.lag = LAG_W'(1);
        end else if (lag_q.lag != {LAG_W{1'b1}}) begin
            lag_d.lag = lag_q.lag + LAG_W'(1);
        end
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            lag_q <= '0;
        end else begin
            lag_q <= lag_d;
        end
    end

    p_latency_bound_r1: assert property (@(posedge clk_src) disable iff (!rst_n)
        lag_q.lag <= LAG_W'(LAG_MAX))
        else $error("stop/start latency exceeded bound");

    p_free_ignores_stop_r4: assert property (@(negedge clk_src) disable iff (!rst_n)
        ($past(rst_n) && $past(free_en)) |-> clk_free)
        else $error("free-running output missed a high phase");

    generate
        for (gi = 0; gi < N_OUT; gi++) begin : g_chk
            p_halted_low_r2: assert property (@(negedge clk_src) disable iff (!rst_n)
                (grp_q.run == GATE_HALT) |-> !clk_gated[gi])
                else $error("gated output high while group halted");
        end
    endgenerate

endmodule

// File: tb/clk_stop_gate_test.sv
module clk_stop_gate_test;

    localparam int  PERIOD = 10;
    localparam real HALF   = PERIOD / 2.0;
    localparam int  N      = 4;
    localparam int  STG    = 2;
    localparam int  WIN    = 8;
    localparam int  NVEC   = 8;

    // {mode, stop_n, free_en, out_en[3:0], exp_gated[3:0], exp_free}
    localparam logic [11:0] VEC [NVEC] = '{
        12'b0_1_1_1111_1111_1,
        12'b0_0_1_1111_0000_1,
        12'b1_0_1_1111_1111_1,
        12'b0_1_0_1010_1010_0,
        12'b0_0_0_0101_0000_0,
        12'b1_0_1_0110_0110_1,
        12'b0_1_1_0001_0001_1,
        12'b0_0_1_1000_0000_1
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_req_n = 1'b1;
    logic         mode_sel = 1'b0;
    logic         tristate = 1'b0;
    logic         free_en = 1'b1;
    logic [N-1:0] out_en = '1;
    logic [N-1:0] clk_gated;
    logic         clk_free;
    logic         pad_oe;

    int checks = 0;
    int fails  = 0;
    int cnt_g [N];
    int cnt_f = 0;
    int bad_w = 0;
    realtime t_rise = 0;

    clk_stop_gate #(.N_OUT(N), .SYNC_STAGES(STG), .USE_MODE(1'b1)) uut (
        .clk_src    (clk),
        .rst_n      (rst_n),
        .stop_req_n (stop_req_n),
        .mode_sel   (mode_sel),
        .tristate   (tristate),
        .free_en    (free_en),
        .out_en     (out_en),
        .clk_gated  (clk_gated),
        .clk_free   (clk_free),
        .pad_oe     (pad_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    initial for (int i = 0; i < N; i++) cnt_g[i] = 0;

    // count high phases one time unit after each source rising edge
    always @(posedge clk) begin
        #1;
        for (int i = 0; i < N; i++) if (clk_gated[i]) cnt_g[i]++;
        if (clk_free) cnt_f++;
    end

    always @(posedge clk_gated[0]) t_rise = $realtime;
    always @(negedge clk_gated[0]) if (($realtime - t_rise) != HALF) bad_w++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic mid();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #2;
    endtask

    initial begin
        #(PERIOD * 50000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base_g [N];
        int base_f;
        int c0;
        // R8: outputs low during reset, sampled in a source high phase
        #17;
        chk("R8 gated in reset", int'(clk_gated), 0);
        chk("R8 free in reset", int'(clk_free), 0);
        #5 rst_n = 1'b1;

        // R7: pad enable follows tristate
        mid();
        chk("R7 oe low", int'(pad_oe), 1);
        tristate = 1'b1;
        #1 chk("R7 oe tristated", int'(pad_oe), 0);
        tristate = 1'b0;

        // table of steady patterns (R2 R4 R5 R6)
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            mode_sel   = VEC[v][11];
            stop_req_n = VEC[v][10];
            free_en    = VEC[v][9];
            out_en     = VEC[v][8:5];
            wait_edges(4);
            for (int i = 0; i < N; i++) base_g[i] = cnt_g[i];
            base_f = cnt_f;
            wait_edges(WIN);
            if (!VEC[v][10] && !VEC[v][11]) tag = "R2 stopped";
            else if (!VEC[v][10]) tag = "R6 masked";
            else tag = "R5 enable";
            for (int i = 0; i < N; i++)
                chk(tag, cnt_g[i] - base_g[i], VEC[v][1+i] ? WIN : 0);
            chk("R4 free", cnt_f - base_f, VEC[v][0] ? WIN : 0);
        end

        // R1: stop latency from a running state
        mode_sel = 1'b0; free_en = 1'b1; out_en = '1; stop_req_n = 1'b1;
        wait_edges(4);
        c0 = cnt_g[0];
        base_f = cnt_f;
        stop_req_n = 1'b0;
        wait_edges(6);
        chk("R1 pulses after stop", cnt_g[0] - c0, STG);
        chk("R4 free during stop", cnt_f - base_f, 6);

        // R3: restart on edge STG+1
        c0 = cnt_g[0];
        stop_req_n = 1'b1;
        wait_edges(STG);
        chk("R3 no early pulse", cnt_g[0] - c0, 0);
        wait_edges(1);
        chk("R3 first pulse", cnt_g[0] - c0, 1);

        // R3: asynchronous enable toggling yields no runt pulses
        for (int k = 0; k < 40; k++) begin
            #7 out_en[0] = ~out_en[0];
        end
        out_en[0] = 1'b1;
        wait_edges(3);
        chk("R3 full-width high phases", bad_w, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule